// File: doc/BRIEF.md
# Embedded Operation Busy Status Reporter

This block stands between the array read path and the host data bus of a byte-programmable, sector-erasable nonvolatile memory. It is started by a one-cycle pulse carrying the kind of embedded operation: byte program, sector erase or chip erase. For a byte program it also takes the top bit of the byte being written. It then stays busy for a parameterised number of clock cycles. A chip erase runs as a sequence of sector-length slices, one per sector.

While busy, the read bus carries status in place of array data. Bit 7 is the polling bit. For a program it holds the inverse of the programmed top bit, and for an erase it reads 0. Bit 6 flips each time the host raises its read strobe. The other bits read 0. When the count runs out, a one-cycle done pulse is raised and the bus passes array data through again. A host can therefore find the end of the operation either by polling bit 7 or by watching bit 6 stop changing.

Top module: `op_status_rpt`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, `sector_o` is 0 and `rd_data_o` equals `array_data_i`.
- R2: While a byte program (`op_i` = 2'b00) is busy, `rd_data_o[7]` is the inverse of `prog_msb_i` as captured at the accepted start.
- R3: While a sector erase (2'b01) or chip erase (2'b10) is busy, `rd_data_o[7]` is 0.
- R4: While busy, `rd_data_o[6]` starts at 0 on each accepted start and inverts once on the clock edge that first sees `rd_i` high after it was low. Holding `rd_i` high causes no further change.
- R5: While busy, `rd_data_o[5:0]` is 0.
- R6: A byte program keeps `busy_o` high for exactly `PROG_CYCLES` cycles after the start edge.
- R7: A sector erase keeps `busy_o` high for exactly `SECT_CYCLES` cycles.
- R8: A chip erase keeps `busy_o` high for `NUM_SECTORS` × `SECT_CYCLES` cycles. During this time `sector_o` starts at 0 and advances by one every `SECT_CYCLES` cycles.
- R9: `done_o` is high for exactly one cycle, namely the first cycle in which `busy_o` is low after an operation.
- R10: A start while busy is ignored: the operation kind, the polling bit and the end time are all unchanged. A start with the reserved code 2'b11 is also ignored.
- R11: While not busy, `rd_data_o` equals `array_data_i`, so after completion bit 7 shows true data and bit 6 no longer toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| prog_msb_i | input | 1 | Bit 7 of the byte being programmed |
| rd_i | input | 1 | Host read strobe, active high |
| array_data_i | input | 8 | True array read data |
| rd_data_o | output | 8 | Data returned to the host |
| busy_o | output | 1 | Embedded operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sector_o | output | SEC_W | Sector slice currently being erased in a chip erase |

## Verification
Several properties are checked on every cycle. Pass-through while idle, zero low bits while busy, the one-cycle shape of `done_o` and its alignment with the falling edge of busy, the range of the sector index, the edge-only behaviour of the toggle bit, and the freezing of the captured operation against a second start are all checked this way. The exact busy durations for each operation kind, the polling-bit value for each programmed byte, the toggle parity after a given number of reads, and the behaviour of the reserved code can only be shown by the bench's scenarios.

// File: rtl/status_rpt_pkg.sv
package status_rpt_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_NONE = 2'b11
  } op_e;
endpackage

// File: rtl/op_timer.sv
module op_timer
  import status_rpt_pkg::*;
#(
  parameter int PROG_CYCLES = 5000,
  parameter int SECT_CYCLES = 2500000,
  parameter int NUM_SECTORS = 256,
  localparam int MAX_CYC = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES,
  localparam int CNT_W   = $clog2(MAX_CYC + 1),
  localparam int SEC_W   = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             msb_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output op_e              op_o,
  output logic             msb_o,
  output logic [SEC_W-1:0] sector_o
);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SECT_LD  = CNT_W'(SECT_CYCLES - 1);
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(NUM_SECTORS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sector_q;
  logic             busy_q, done_q, msb_q;
  op_e              op_q;

  assign accept_o = start_i && !busy_q && (op_e'(op_i) != OP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sector_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      msb_q    <= 1'b0;
      op_q     <= OP_PROG;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q   <= 1'b1;
        op_q     <= op_e'(op_i);
        msb_q    <= msb_i;
        sector_q <= '0;
        cnt_q    <= (op_e'(op_i) == OP_PROG) ? PROG_LD : SECT_LD;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          // chip erase walks the sectors one slice at a time
          if (op_q == OP_CHIP && sector_q != LAST_SEC) begin
            sector_q <= sector_q + 1'b1;
            cnt_q    <= SECT_LD;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign op_o     = op_q;
  assign msb_o    = msb_q;
  assign sector_o = sector_q;

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_at_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));
  p_sector_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_q <= LAST_SEC);
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(op_q) && $stable(msb_q)));
endmodule

// File: rtl/rd_toggle.sv
module rd_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic rd_i,
  output logic tog_o
);
  logic rd_q, tog_q;
  logic rd_rise;

  assign rd_rise = rd_i && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (clr_i)                tog_q <= 1'b0;
      else if (en_i && rd_rise) tog_q <= ~tog_q;
    end
  end

  assign tog_o = tog_q;

  p_tog_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !rd_rise) |=> $stable(tog_q));
  p_tog_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && rd_rise) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/status_mux.sv
module status_mux
  import status_rpt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  op_e           op_i,
  input  logic          msb_i,
  input  logic          tog_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] rd_data_o
);
  always_comb begin
    if (busy_i) begin
      rd_data_o       = '0;
      rd_data_o[DW-1] = (op_i == OP_PROG) ? ~msb_i : 1'b0;
      rd_data_o[DW-2] = tog_i;
    end else begin
      rd_data_o = array_i;
    end
  end

  p_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (rd_data_o[DW-3:0] == '0));
  p_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (rd_data_o == array_i));
endmodule

// File: rtl/op_status_rpt.sv
module op_status_rpt
  import status_rpt_pkg::*;
#(
  parameter int PROG_CYCLES = 5000,
  parameter int SECT_CYCLES = 2500000,
  parameter int NUM_SECTORS = 256,
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             prog_msb_i,
  input  logic             rd_i,
  input  logic [7:0]       array_data_i,
  output logic [7:0]       rd_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [SEC_W-1:0] sector_o
);
  logic accept, msb_q, tog;
  op_e  op_q;

  op_timer #(
    .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES),
    .NUM_SECTORS(NUM_SECTORS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .msb_i   (prog_msb_i),
    .accept_o(accept),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .op_o    (op_q),
    .msb_o   (msb_q),
    .sector_o(sector_o)
  );

  rd_toggle u_tog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (busy_o),
    .rd_i  (rd_i),
    .tog_o (tog)
  );

  status_mux #(.DW(8)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_o),
    .op_i     (op_q),
    .msb_i    (msb_q),
    .tog_i    (tog),
    .array_i  (array_data_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/tb_op_status_rpt.sv
module tb_op_status_rpt;
  localparam int PC = 12;
  localparam int SC = 30;
  localparam int NS = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic          prog_msb_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [7:0]    array_data_i = 8'h5C;
  logic [7:0]    rd_data_o;
  logic          busy_o, done_o;
  logic [SW-1:0] sector_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  op_status_rpt #(.PROG_CYCLES(PC), .SECT_CYCLES(SC), .NUM_SECTORS(NS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .prog_msb_i(prog_msb_i), .rd_i(rd_i), .array_data_i(array_data_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o), .sector_o(sector_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // {op[1:0], msb, reads[1:0], exp bit7, exp bit6}
  localparam int NV = 7;
  localparam logic [6:0] VEC [NV] = '{
    {2'b00, 1'b1, 2'd0, 1'b0, 1'b0},
    {2'b00, 1'b0, 2'd1, 1'b1, 1'b1},
    {2'b00, 1'b1, 2'd2, 1'b0, 1'b0},
    {2'b00, 1'b0, 2'd3, 1'b1, 1'b1},
    {2'b01, 1'b1, 2'd1, 1'b0, 1'b1},
    {2'b01, 1'b0, 2'd2, 1'b0, 1'b0},
    {2'b10, 1'b0, 2'd3, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic [1:0] op, input logic msb, output int t0);
    @(negedge clk);
    start_i = 1'b1; op_i = op; prog_msb_i = msb;
    @(negedge clk);
    start_i = 1'b0;
    t0 = cyc;
  endtask

  task automatic do_read();
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic wait_end(output int t1);
    while (busy_o) @(negedge clk);
    t1 = cyc;
  endtask

  initial begin
    int t0, t1, exp_d;
    logic [1:0] op;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && sector_o == 0, "R1 idle flags", {busy_o, done_o}, 0);
    chk(rd_data_o == array_data_i, "R1 pass-through", rd_data_o, array_data_i);

    for (int i = 0; i < NV; i++) begin
      op = VEC[i][6:5];
      start_op(op, VEC[i][4], t0);
      for (int r = 0; r < int'(VEC[i][3:2]); r++) do_read();
      chk(rd_data_o[7] == VEC[i][1], (op == 2'b00) ? "R2 poll bit" : "R3 poll bit", rd_data_o[7], VEC[i][1]);
      chk(rd_data_o[6] == VEC[i][0], "R4 toggle parity", rd_data_o[6], VEC[i][0]);
      chk(rd_data_o[5:0] == 6'd0, "R5 low bits", rd_data_o[5:0], 0);
      array_data_i = (op == 2'b00) ? {VEC[i][4], 7'h35} : 8'hFF;
      wait_end(t1);
      exp_d = (op == 2'b00) ? PC : (op == 2'b01) ? SC : NS * SC;
      chk(t1 - t0 == exp_d, (op == 2'b00) ? "R6 duration" : (op == 2'b01) ? "R7 duration" : "R8 duration",
          t1 - t0, exp_d);
      chk(done_o == 1'b1, "R9 done high", done_o, 1);
      chk(rd_data_o == array_data_i, "R11 true data", rd_data_o, array_data_i);
      @(negedge clk);
      chk(done_o == 1'b0, "R9 done width", done_o, 0);
    end

    // R10: second start while busy
    start_op(2'b00, 1'b0, t0);
    repeat (3) @(negedge clk);
    start_i = 1'b1; op_i = 2'b01; prog_msb_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(rd_data_o[7] == 1'b1, "R10 poll bit kept", rd_data_o[7], 1);
    wait_end(t1);
    chk(t1 - t0 == PC, "R10 duration kept", t1 - t0, PC);

    // R10: reserved code
    array_data_i = 8'hA7;
    start_op(2'b11, 1'b0, t0);
    chk(busy_o == 1'b0, "R10 reserved busy", busy_o, 0);
    chk(rd_data_o == 8'hA7, "R10 reserved data", rd_data_o, 8'hA7);

    // R4: held strobe flips once
    start_op(2'b01, 1'b0, t0);
    rd_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_data_o[6] == 1'b1, "R4 held strobe", rd_data_o[6], 1);
    rd_i = 1'b0;
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk);
    chk(rd_data_o[6] == 1'b0, "R4 second rise", rd_data_o[6], 0);
    rd_i = 1'b0;
    wait_end(t1);
    @(negedge clk);

    // R8: sector sequencing
    start_op(2'b10, 1'b0, t0);
    chk(sector_o == 0, "R8 first sector", sector_o, 0);
    repeat (SC) @(negedge clk);
    chk(sector_o == 1, "R8 second sector", sector_o, 1);
    repeat (SC) @(negedge clk);
    chk(sector_o == 2, "R8 third sector", sector_o, 2);
    wait_end(t1);
    chk(t1 - t0 == NS * SC, "R8 chip duration", t1 - t0, NS * SC);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule